// File: doc/BRIEF.md
# PS/2 keyboard wake sequence detector

This block listens to the two lines of a PS/2 keyboard link and never drives them. It oversamples the clock and data lines with the system clock and rebuilds each 11-bit frame the keyboard sends. Every frame that arrives intact is compared against a pattern of up to eight programmed bytes. When the pattern is complete, a single-cycle wake pulse goes to the status and routing logic downstream.

A 4-bit control field picks the matching rule. The rule is one of these: off, any key pressed, a password of 1 to 8 keystrokes in which release codes are ignored, or a raw sequence of 2 to 8 bytes in which every received byte counts. The block reports nothing until the standby supply has been good for a programmable number of cycles. The received bytes pass from the deserialiser to the matcher as a valid-only stream with no ready signal. The matcher consumes a byte in the same cycle it is offered, so the stream never applies back-pressure and no byte is held or queued.

Top module: `kbd_wake_matcher`

## Requirements
- R1: The frame receiver samples the data line at each falling edge of the PS/2 clock. A frame is a start bit of 0, eight data bits with the LSB first, a parity bit that makes the count of ones across data and parity odd, and a stop bit of 1. Nothing is sampled while the PS/2 clock stays still.
- R2: A frame with bad parity, a start bit of 1 or a stop bit of 0 delivers no byte and clears any partial match progress.
- R3: When IDLE_CYCLES system clocks pass without a falling edge in the middle of a frame, the bits gathered so far are discarded, and the next falling edge is taken as a start bit.
- R4: The control field `seq_ctl` selects the mode. A value of 0 disables matching. A value of 1 with key bytes 0 and 1 both 00h selects any-keystroke detection. Any other value from 1 to 7 selects a raw sequence of `seq_ctl`+1 bytes. Values from 8 to 15 select a password of `seq_ctl`-7 keystrokes.
- R5: In any-keystroke mode, each make code produces a wake pulse. A make code is a byte that is not F0h and does not directly follow F0h.
- R6: In password mode, F0h and the byte after it are skipped. Each remaining byte is compared in order against key byte n, where key byte n is `key_bytes[8n+7:8n]`.
- R7: In raw-sequence mode, every received byte is a sequence element, F0h included.
- R8: A byte that mismatches the current element restarts the match. That same byte is then compared against element 0, and if it equals key byte 0, matching continues from element 1.
- R9: A completed pattern raises `wake_pulse` for exactly one clock cycle, and matching then starts again from element 0.
- R10: No wake pulse occurs until `standby_ok` has been high for ARM_CYCLES consecutive clocks. Bytes that complete before that point are ignored. Dropping `standby_ok` disarms the block and clears the match progress.
- R11: After reset, `wake_pulse` is low and no match progress is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ps2_clk | input | 1 | PS/2 clock line, observed only |
| ps2_dat | input | 1 | PS/2 data line, observed only |
| standby_ok | input | 1 | Standby supply good, synchronous level |
| seq_ctl | input | 4 | Mode and length control field |
| key_bytes | input | 64 | Eight key bytes; byte n in bits 8n+7:8n |
| wake_pulse | output | 1 | One-cycle keyboard wake event |

## Verification
Two functions can act in the same cycle: the arming timer reaching its limit, and a byte completing and being offered to the matcher. The bench provokes this by lowering and raising `standby_ok` and then starting a frame at several offsets. The offsets are chosen so that the last falling edge lands a few cycles before, exactly on, and a few cycles after the arming cycle. A cycle-exact behavioural model in the bench decides whether each of those bytes is accepted, and the model's prediction is compared with `wake_pulse` on every clock.

// File: rtl/kbw_pkg.sv
package kbw_pkg;
  parameter int unsigned KEY_W      = 8;
  parameter int unsigned NUM_KEYS   = 8;
  parameter int unsigned CTL_W      = 4;
  parameter int unsigned FRAME_BITS = 11;
  localparam int unsigned IDX_W     = $clog2(NUM_KEYS);
  localparam logic [KEY_W-1:0] BRK_PREFIX = 8'hF0;

  typedef enum logic [1:0] {
    MODE_OFF  = 2'd0,
    MODE_ANY  = 2'd1,
    MODE_PASS = 2'd2,
    MODE_RAW  = 2'd3
  } mode_e;
endpackage

// File: rtl/kbw_frame_rx.sv
module kbw_frame_rx
  import kbw_pkg::*;
#(
  parameter int unsigned IDLE_CYCLES = 100_000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ps2_clk,
  input  logic             ps2_dat,
  output logic             byte_vld,
  output logic             frame_err,
  output logic [KEY_W-1:0] byte_q
);
  localparam int unsigned CNT_W  = $clog2(FRAME_BITS + 1);
  localparam int unsigned IDLE_W = $clog2(IDLE_CYCLES + 1);

  logic              c_s1, c_s2, c_s3, d_s1, d_s2;
  logic [FRAME_BITS-1:0] shreg;
  logic [CNT_W-1:0]  bit_cnt;
  logic [IDLE_W-1:0] idle_cnt;
  logic              fall;
  logic [FRAME_BITS-1:0] frame_w;
  logic              frame_ok;

  assign fall    = c_s3 & ~c_s2;
  assign frame_w = {d_s2, shreg[FRAME_BITS-1:1]};
  assign frame_ok = ~frame_w[0] & frame_w[FRAME_BITS-1] & (^frame_w[FRAME_BITS-2:1]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_s1 <= 1'b1; c_s2 <= 1'b1; c_s3 <= 1'b1;
      d_s1 <= 1'b1; d_s2 <= 1'b1;
    end else begin
      c_s1 <= ps2_clk; c_s2 <= c_s1; c_s3 <= c_s2;
      d_s1 <= ps2_dat; d_s2 <= d_s1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg     <= '0;
      bit_cnt   <= '0;
      idle_cnt  <= '0;
      byte_vld  <= 1'b0;
      frame_err <= 1'b0;
      byte_q    <= '0;
    end else begin
      byte_vld  <= 1'b0;
      frame_err <= 1'b0;
      if (fall) begin
        shreg    <= frame_w;
        idle_cnt <= '0;
        if (bit_cnt == CNT_W'(FRAME_BITS - 1)) begin
          bit_cnt   <= '0;
          byte_vld  <= frame_ok;
          frame_err <= ~frame_ok;
          byte_q    <= frame_w[KEY_W:1];
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
        end
      end else if (bit_cnt != '0) begin
        if (idle_cnt == IDLE_W'(IDLE_CYCLES - 1)) begin
          bit_cnt  <= '0;
          idle_cnt <= '0;
        end else begin
          idle_cnt <= idle_cnt + 1'b1;
        end
      end
    end
  end

  // R1: a byte or an error only appears right after the eleventh sampled bit
  a_r1_eleventh_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld || frame_err) |-> ($past(bit_cnt) == CNT_W'(FRAME_BITS - 1)));
  // R3: a partial frame never outlives the idle window
  a_r3_idle_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_cnt <= IDLE_W'(IDLE_CYCLES - 1)));
endmodule

// File: rtl/kbw_arm_timer.sv
module kbw_arm_timer #(
  parameter int unsigned ARM_CYCLES = 50_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic standby_ok,
  output logic armed
);
  localparam int unsigned AW = $clog2(ARM_CYCLES + 1);
  logic [AW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      armed <= 1'b0;
    end else if (!standby_ok) begin
      cnt   <= '0;
      armed <= 1'b0;
    end else if (!armed) begin
      if (cnt == AW'(ARM_CYCLES - 1)) armed <= 1'b1;
      else                            cnt   <= cnt + 1'b1;
    end
  end

  // R10: the armed state requires the supply to have been good
  a_r10_armed_needs_supply: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> $past(standby_ok));
endmodule

// File: rtl/kbw_seq_match.sv
module kbw_seq_match
  import kbw_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      armed,
  input  logic                      byte_vld,
  input  logic                      frame_err,
  input  logic [KEY_W-1:0]          byte_q,
  input  logic [CTL_W-1:0]          seq_ctl,
  input  logic [NUM_KEYS*KEY_W-1:0] key_bytes,
  output logic                      wake_pulse
);
  mode_e            mode;
  logic [IDX_W-1:0] last_idx;
  logic [IDX_W-1:0] idx_q;
  logic             skip_q;
  logic             is_brk, elem;
  logic [KEY_W-1:0] key_cur, key_first;

  always_comb begin
    last_idx = seq_ctl[IDX_W-1:0];
    if (seq_ctl == '0)
      mode = MODE_OFF;
    else if (seq_ctl == CTL_W'(1) && key_bytes[2*KEY_W-1:0] == '0)
      mode = MODE_ANY;
    else if (!seq_ctl[CTL_W-1])
      mode = MODE_RAW;
    else
      mode = MODE_PASS;
  end

  assign key_cur   = key_bytes[idx_q*KEY_W +: KEY_W];
  assign key_first = key_bytes[KEY_W-1:0];
  assign is_brk    = (byte_q == BRK_PREFIX);
  assign elem      = (mode == MODE_RAW) || (!skip_q && !is_brk);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q      <= '0;
      skip_q     <= 1'b0;
      wake_pulse <= 1'b0;
    end else begin
      wake_pulse <= 1'b0;
      if (!armed || frame_err || mode == MODE_OFF) begin
        idx_q  <= '0;
        skip_q <= 1'b0;
      end else if (byte_vld) begin
        skip_q <= (mode != MODE_RAW) && !skip_q && is_brk;
        if (elem) begin
          if (mode == MODE_ANY) begin
            wake_pulse <= 1'b1;
          end else if (byte_q == key_cur) begin
            if (idx_q >= last_idx) begin
              wake_pulse <= 1'b1;
              idx_q      <= '0;
            end else begin
              idx_q <= idx_q + 1'b1;
            end
          end else begin
            idx_q <= (byte_q == key_first) ? IDX_W'(1) : '0;
          end
        end
      end
    end
  end

  // R9: the wake event lasts one cycle
  a_r9_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |=> !wake_pulse);
  // R10: no event unless armed when the byte was taken
  a_r10_wake_when_armed: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |-> $past(armed));
  // R2: a damaged frame drops progress
  a_r2_err_clears: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |=> (idx_q == '0));
  // R1: an event only follows a delivered byte
  a_r1_wake_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |-> $past(byte_vld));
endmodule

// File: rtl/kbd_wake_matcher.sv
module kbd_wake_matcher
  import kbw_pkg::*;
#(
  parameter int unsigned ARM_CYCLES  = 50_000_000,
  parameter int unsigned IDLE_CYCLES = 100_000
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ps2_clk,
  input  logic                      ps2_dat,
  input  logic                      standby_ok,
  input  logic [CTL_W-1:0]          seq_ctl,
  input  logic [NUM_KEYS*KEY_W-1:0] key_bytes,
  output logic                      wake_pulse
);
  logic             rx_vld, rx_err, armed;
  logic [KEY_W-1:0] rx_byte;

  kbw_frame_rx #(.IDLE_CYCLES(IDLE_CYCLES)) u_rx (
    .clk(clk), .rst_n(rst_n), .ps2_clk(ps2_clk), .ps2_dat(ps2_dat),
    .byte_vld(rx_vld), .frame_err(rx_err), .byte_q(rx_byte)
  );

  kbw_arm_timer #(.ARM_CYCLES(ARM_CYCLES)) u_arm (
    .clk(clk), .rst_n(rst_n), .standby_ok(standby_ok), .armed(armed)
  );

  kbw_seq_match u_match (
    .clk(clk), .rst_n(rst_n), .armed(armed), .byte_vld(rx_vld),
    .frame_err(rx_err), .byte_q(rx_byte), .seq_ctl(seq_ctl),
    .key_bytes(key_bytes), .wake_pulse(wake_pulse)
  );

  // R4: a control value of zero never yields an event
  a_r4_off_silent: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |-> ($past(seq_ctl, 2) != '0 || $past(seq_ctl) != '0));
endmodule

// File: tb/tb_kbd_wake_matcher.sv
module tb_kbd_wake_matcher;
  localparam int CLK_PERIOD = 10;
  localparam int ARM  = 200;
  localparam int IDLE = 30;
  localparam int H    = 5;
  localparam int GAP  = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ps2_clk = 1'b1, ps2_dat = 1'b1, standby_ok = 1'b0;
  logic [3:0] seq_ctl = 4'd0;
  logic [7:0] kv [8];
  logic [63:0] key_bytes;
  logic wake_pulse;

  int n_checks = 0, n_fail = 0, pulses = 0, cycles = 0;
  string cur_req = "R11";

  always #(CLK_PERIOD/2) clk = ~clk;

  always_comb for (int i = 0; i < 8; i++) key_bytes[i*8 +: 8] = kv[i];

  kbd_wake_matcher #(.ARM_CYCLES(ARM), .IDLE_CYCLES(IDLE)) dut (
    .clk(clk), .rst_n(rst_n), .ps2_clk(ps2_clk), .ps2_dat(ps2_dat),
    .standby_ok(standby_ok), .seq_ctl(seq_ctl), .key_bytes(key_bytes),
    .wake_pulse(wake_pulse)
  );

  // ---------------- behavioural reference model ----------------
  bit ch[$], dh[$], frame[$];
  int m_idle, m_arm_cnt, m_idx;
  bit m_armed, m_vld, m_err, m_skip, exp_wake;
  logic [7:0] m_byte;

  function automatic int mode_of();
    if (seq_ctl == 0) return 0;
    if (seq_ctl == 1 && kv[0] == 0 && kv[1] == 0) return 1;
    if (seq_ctl < 8) return 3;
    return 2;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ch = {1, 1, 1, 1}; dh = {1, 1, 1, 1}; frame = {};
      m_idle = 0; m_arm_cnt = 0; m_idx = 0;
      m_armed = 0; m_vld = 0; m_err = 0; m_skip = 0; exp_wake = 0; m_byte = 0;
    end else begin
      int md, last;
      bit f, el, nv, ne;
      logic [7:0] nb;
      md = mode_of(); last = seq_ctl % 8;
      exp_wake = 0;
      if (!m_armed || m_err || md == 0) begin
        m_idx = 0; m_skip = 0;
      end else if (m_vld) begin
        el = (md == 3) || (!m_skip && m_byte != 8'hF0);
        m_skip = (md != 3) && !m_skip && m_byte == 8'hF0;
        if (el) begin
          if (md == 1) exp_wake = 1;
          else if (m_byte == kv[m_idx]) begin
            if (m_idx >= last) begin exp_wake = 1; m_idx = 0; end
            else m_idx++;
          end else m_idx = (m_byte == kv[0]) ? 1 : 0;
        end
      end
      if (!standby_ok) begin m_arm_cnt = 0; m_armed = 0; end
      else if (!m_armed) begin
        if (m_arm_cnt == ARM - 1) m_armed = 1; else m_arm_cnt++;
      end
      ch.push_front(ps2_clk); dh.push_front(ps2_dat);
      void'(ch.pop_back()); void'(dh.pop_back());
      f = ch[3] && !ch[2];
      nv = 0; ne = 0; nb = m_byte;
      if (f) begin
        frame.push_back(dh[2]); m_idle = 0;
        if (frame.size() == 11) begin
          for (int i = 0; i < 8; i++) nb[i] = frame[1+i];
          ne = frame[0] || !frame[10] || !(^{nb, frame[9]});
          nv = !ne;
          frame = {};
        end
      end else if (frame.size() > 0) begin
        if (m_idle == IDLE - 1) begin frame = {}; m_idle = 0; end
        else m_idle++;
      end
      m_vld = nv; m_err = ne; m_byte = nb;
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      n_checks++;
      if (wake_pulse !== exp_wake) begin
        n_fail++;
        $display("FAIL %s per-cycle model: wake_pulse act=%0b exp=%0b at cycle %0d",
                 cur_req, wake_pulse, exp_wake, cycles);
      end
      if (wake_pulse === 1'b1) pulses++;
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bits(input logic [10:0] fr, input int nbits);
    for (int i = 0; i < nbits; i++) begin
      ps2_dat = fr[i]; tick(H); ps2_clk = 1'b0; tick(H); ps2_clk = 1'b1;
    end
    ps2_dat = 1'b1;
  endtask

  task automatic send_frame(input logic [7:0] b, input bit bad_par, input bit bad_stop);
    logic p;
    p = ~(^b) ^ bad_par;
    send_bits({~bad_stop, p, b, 1'b0}, 11);
    tick(GAP);
  endtask

  task automatic sb(input logic [7:0] b);
    send_frame(b, 1'b0, 1'b0);
  endtask

  task automatic press(input logic [7:0] code);
    sb(code); sb(8'hF0); sb(code);
  endtask

  task automatic set_keys(input logic [63:0] v);
    for (int i = 0; i < 8; i++) kv[i] = v[i*8 +: 8];
  endtask

  task automatic expect_pulses(input string req, input int exp);
    tick(10);
    check(pulses == exp, req, pulses, exp);
    pulses = 0;
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #(CLK_PERIOD * 150000);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  // ---------------- test sequence ----------------
  initial begin
    set_keys(64'h0);
    seq_ctl = 4'd1;
    tick(4);
    check(wake_pulse === 1'b0, "R11 reset", wake_pulse, 0);
    rst_n = 1'b1;
    tick(2);
    check(wake_pulse === 1'b0, "R11 after release", wake_pulse, 0);

    cur_req = "R10"; pulses = 0;
    press(8'h1C);
    expect_pulses("R10 unpowered", 0);
    standby_ok = 1'b1;
    sb(8'h1C);
    expect_pulses("R10 before arm window", 0);
    tick(ARM);
    cur_req = "R5";
    press(8'h1C);
    expect_pulses("R5 any keystroke make only", 1);

    cur_req = "R10";
    for (int off = -4; off <= 4; off++) begin
      standby_ok = 1'b0; tick(3); standby_ok = 1'b1;
      tick(ARM - 110 + off);
      sb(8'h2A);
    end
    tick(ARM); pulses = 0;

    cur_req = "R6";
    set_keys(64'h0000_0000_0021_321C);
    seq_ctl = 4'd10;
    press(8'h1C); press(8'h32); press(8'h21);
    expect_pulses("R6 password of three", 1);
    press(8'h1C); press(8'h33); press(8'h21);
    expect_pulses("R6 wrong keystroke", 0);

    cur_req = "R8";
    press(8'h1C); press(8'h1C); press(8'h32); press(8'h21);
    expect_pulses("R8 restart rechecks element 0", 1);

    cur_req = "R2";
    press(8'h1C); send_frame(8'h32, 1'b1, 1'b0); press(8'h21);
    expect_pulses("R2 parity error drops", 0);
    press(8'h1C); press(8'h32); send_frame(8'h21, 1'b0, 1'b1);
    expect_pulses("R2 stop error drops", 0);

    cur_req = "R9";
    set_keys(64'h4433_2211_4D3C_2B1A);
    seq_ctl = 4'd15;
    for (int i = 0; i < 8; i++) press(kv[i]);
    expect_pulses("R9 eight keystroke password single pulse", 1);
    seq_ctl = 4'd8;
    press(8'h1A);
    expect_pulses("R4 password of one", 1);
    press(8'h2B);
    expect_pulses("R4 password of one other key", 0);

    cur_req = "R7";
    set_keys(64'h0000_0000_005A_F0E0);
    seq_ctl = 4'd2;
    sb(8'hE0); sb(8'hF0); sb(8'h5A);
    expect_pulses("R7 raw with break prefix", 1);
    sb(8'hE0); sb(8'h5A);
    expect_pulses("R7 raw missing element", 0);
    set_keys(64'h0000_0000_0000_7712);
    seq_ctl = 4'd1;
    sb(8'h12); sb(8'h77);
    expect_pulses("R4 value one with keys set is raw of two", 1);

    cur_req = "R3";
    set_keys(64'h0);
    seq_ctl = 4'd1;
    send_bits(11'h5A5, 4); tick(IDLE + 30);
    sb(8'h29);
    expect_pulses("R3 partial frame discarded", 1);

    cur_req = "R4";
    seq_ctl = 4'd0;
    press(8'h29);
    expect_pulses("R4 disabled", 0);

    cur_req = "R10";
    set_keys(64'h0000_0000_0000_3121);
    seq_ctl = 4'd9;
    press(8'h21);
    standby_ok = 1'b0; tick(2); standby_ok = 1'b1; tick(ARM + 5);
    press(8'h31);
    expect_pulses("R10 supply drop clears progress", 0);

    tick(20);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule